// File: doc/BRIEF.md
# Emulator Bus Steering Controller

This block sits between an emulation processor and two bus sides: the target system the processor has been plugged into, and the emulator console that controls it. In run mode every processor cycle is passed straight through to the target. The address travels outward only. The data direction follows the write strobe. While cycles pass through, the block compares each one against four breakpoint addresses. For every read it also decides whether the returned byte comes from the target, from a low-memory overlay RAM, or from a small RAM that stands in for the vector block at the top of memory.

A breakpoint hit or a console break command raises a single-cycle non-maskable interrupt. On the same clock edge the block moves the processor onto the console buses. While the processor runs console code, all target outputs are released and no target cycle can occur. The console hands control back by writing a resume command. Overlay and vector contents are loaded through a separate load stream, and only while the console holds control. A configuration bit can stop the target's reset line from disturbing the control state.

Processor cycles use valid/ready handshaking. A cycle is taken when `cpu_valid` and `cpu_ready` are both high. `cpu_ready` drops only during the interrupt cycle. Read data comes back with `cpu_rvalid` exactly one cycle after acceptance, and the result path has no back-pressure. The load stream is taken on `ld_valid && ld_ready`, and `ld_ready` is high only in console mode.

Top module: `ice_bus_steer`

## Requirements
- R1: After reset the block is in run mode with `cpu_nmi`, `cpu_on_console` and `bkpt_hit` low and `cpu_ready` high. In run mode an accepted cycle drives `tgt_valid` in the same cycle, with `tgt_addr` = `cpu_addr`, `tgt_we` = `cpu_we`, `tgt_wdata` = `cpu_wdata` and `tgt_addr_oe` high, while `con_bus_valid` stays low.
- R2: `tgt_data_oe` is high only during an accepted target write. Read data from any source appears on `cpu_rdata` with `cpu_rvalid` in the cycle after the read is accepted, and a target read returns the `tgt_rdata` value of that cycle.
- R3: When configuration bit 0 is set, a read from an address below 0xC000 returns the overlay RAM byte at index `addr[OVL_AW-1:0]`. Reads from 0xC000 upward, or with the bit clear, return target data.
- R4: When configuration bit 1 is set, a read from 0xFFF0–0xFFFF returns vector RAM at index `addr[3:0]`. Processor writes to that range produce no target cycle (`tgt_valid` low) and leave the vector RAM unchanged.
- R5: Register selects 0–3 hold breakpoint addresses and configuration bits 4–7 enable them. An enabled match on an accepted run-mode cycle sets the matching bit of `bkpt_hit` from the next cycle on. The bit stays set until command bit 2 clears it. A disabled entry never sets.
- R6: A breakpoint hit raises `cpu_nmi` for exactly one cycle, the cycle after the matching cycle, and the block is in console mode from that same cycle. `cpu_ready` is low during the interrupt cycle.
- R7: In console mode accepted cycles go to the console bus (`con_bus_valid`, `con_bus_we`, `con_bus_addr`, `con_bus_wdata`), and reads return `con_bus_rdata`. `tgt_valid`, `tgt_we`, `tgt_addr_oe` and `tgt_data_oe` all stay low.
- R8: Writing select 5 with bit 0 set returns to run mode from the next cycle. Writing select 5 with bit 1 set while in run mode causes the same interrupt and bus swap as a breakpoint.
- R9: `ld_ready` equals `cpu_on_console`. An accepted load below 0xC000 writes the overlay, one at 0xFFF0 or above writes the vector RAM, and any other address is dropped.
- R10: A low `tgt_rst_n` at a clock edge with configuration bit 2 clear forces run mode, drops `cpu_nmi` and clears `bkpt_hit`. With bit 2 set it has no effect. Configuration and RAM contents survive a target reset either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Emulator reset, active low, asynchronous |
| tgt_rst_n | input | 1 | Reset line from the target, active low |
| cpu_valid | input | 1 | Processor cycle request |
| cpu_ready | output | 1 | Processor cycle accepted when high |
| cpu_we | input | 1 | Processor cycle is a write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | DW | Read data to processor |
| cpu_nmi | output | 1 | Non-maskable interrupt pulse |
| tgt_valid | output | 1 | Target bus cycle strobe |
| tgt_we | output | 1 | Target write strobe |
| tgt_addr | output | AW | Target address |
| tgt_addr_oe | output | 1 | Target address buffer enable |
| tgt_wdata | output | DW | Target write data |
| tgt_data_oe | output | 1 | Target data buffer drive enable |
| tgt_rdata | input | DW | Target read data |
| con_bus_valid | output | 1 | Console bus cycle strobe |
| con_bus_we | output | 1 | Console bus write strobe |
| con_bus_addr | output | AW | Console bus address |
| con_bus_wdata | output | DW | Console bus write data |
| con_bus_rdata | input | DW | Console bus read data |
| con_wr | input | 1 | Control register write |
| con_sel | input | SEL_W | Control register select |
| con_wdata | input | AW | Control register write data |
| ld_valid | input | 1 | Overlay/vector load request |
| ld_ready | output | 1 | Load accepted when high |
| ld_addr | input | AW | Load address |
| ld_data | input | DW | Load data |
| cpu_on_console | output | 1 | Processor steered to console buses |
| bkpt_hit | output | NUM_BP | Latched breakpoint flags |

## Verification
A wrong mode bit shows at once: cycles appear on the wrong bus side in the very cycle they are accepted, and `ld_ready` disagrees with the steering. A stuck or mis-set read-source register shows one cycle after a read, as a byte from the wrong source on `cpu_rdata`. The bench predicts each such byte independently from the target, console and overlay models. A lost or spurious breakpoint flag shows on `bkpt_hit` one cycle after the cycle that should or should not have matched. An interrupt pulse held for more than one cycle shows as a second consecutive cycle of `cpu_nmi` together with a low `cpu_ready`.

// File: rtl/ice_steer_pkg.sv
`timescale 1ns/1ps
package ice_steer_pkg;
  typedef enum logic {MODE_RUN, MODE_CONSOLE} mode_e;
  typedef enum logic [1:0] {SRC_TGT, SRC_OVL, SRC_VEC, SRC_CON} rsrc_e;
  localparam int CFG_OVL_BIT   = 0;
  localparam int CFG_VEC_BIT   = 1;
  localparam int CFG_RMASK_BIT = 2;
  localparam int CFG_BPEN_LSB  = 4;
  localparam int CMD_RESUME    = 0;
  localparam int CMD_BREAK     = 1;
  localparam int CMD_CLEAR     = 2;
endpackage

// File: rtl/ice_sync_ram.sv
`timescale 1ns/1ps
module ice_sync_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 2 ** IDX_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ice_bkpt_match.sv
`timescale 1ns/1ps
module ice_bkpt_match #(
  parameter int NUM_BP = 4,
  parameter int AW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_clr,
  input  logic                       flag_clr,
  input  logic                       probe,
  input  logic [AW-1:0]              probe_addr,
  input  logic [NUM_BP-1:0][AW-1:0]  bp_addr,
  input  logic [NUM_BP-1:0]          bp_en,
  output logic                       hit_now,
  output logic [NUM_BP-1:0]          hit_flags
);
  logic [NUM_BP-1:0] match;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    assign match[g] = probe && bp_en[g] && (probe_addr == bp_addr[g]);
  end

  assign hit_now = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hit_flags <= '0;
    else if (soft_clr) hit_flags <= '0;
    else               hit_flags <= (flag_clr ? '0 : hit_flags) | match;
  end
endmodule

// File: rtl/ice_mode_ctrl.sv
`timescale 1ns/1ps
module ice_mode_ctrl
  import ice_steer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  brk_evt,
  input  logic  resume,
  output mode_e mode_q,
  output logic  nmi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      nmi_q  <= 1'b0;
    end else if (soft_rst) begin
      mode_q <= MODE_RUN;
      nmi_q  <= 1'b0;
    end else begin
      nmi_q <= 1'b0;
      if (mode_q == MODE_RUN && brk_evt) begin
        mode_q <= MODE_CONSOLE;
        nmi_q  <= 1'b1;
      end else if (mode_q == MODE_CONSOLE && resume) begin
        mode_q <= MODE_RUN;
      end
    end
  end
endmodule

// File: rtl/ice_bus_steer.sv
`timescale 1ns/1ps
module ice_bus_steer
  import ice_steer_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NUM_BP    = 4,
  parameter int OVL_AW    = 8,
  parameter int VEC_AW    = 4,
  parameter int OVL_LIMIT = 'hC000,
  localparam int SEL_W    = $clog2(NUM_BP + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_rst_n,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic               cpu_rvalid,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_nmi,
  output logic               tgt_valid,
  output logic               tgt_we,
  output logic [AW-1:0]      tgt_addr,
  output logic               tgt_addr_oe,
  output logic [DW-1:0]      tgt_wdata,
  output logic               tgt_data_oe,
  input  logic [DW-1:0]      tgt_rdata,
  output logic               con_bus_valid,
  output logic               con_bus_we,
  output logic [AW-1:0]      con_bus_addr,
  output logic [DW-1:0]      con_bus_wdata,
  input  logic [DW-1:0]      con_bus_rdata,
  input  logic               con_wr,
  input  logic [SEL_W-1:0]   con_sel,
  input  logic [AW-1:0]      con_wdata,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [AW-1:0]      ld_addr,
  input  logic [DW-1:0]      ld_data,
  output logic               cpu_on_console,
  output logic [NUM_BP-1:0]  bkpt_hit
);
  localparam logic [SEL_W-1:0] SEL_CFG = SEL_W'(NUM_BP);
  localparam logic [SEL_W-1:0] SEL_CMD = SEL_W'(NUM_BP + 1);
  localparam logic [AW-1:0]    OVL_TOP = AW'(OVL_LIMIT);

  // configuration and breakpoint address registers
  logic                      cfg_ovl, cfg_vec, cfg_rmask;
  logic [NUM_BP-1:0]         cfg_bpen;
  logic [NUM_BP-1:0][AW-1:0] bp_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ovl   <= 1'b0;
      cfg_vec   <= 1'b0;
      cfg_rmask <= 1'b0;
      cfg_bpen  <= '0;
      bp_addr_q <= '0;
    end else if (con_wr) begin
      for (int i = 0; i < NUM_BP; i++)
        if (con_sel == SEL_W'(i)) bp_addr_q[i] <= con_wdata;
      if (con_sel == SEL_CFG) begin
        cfg_ovl   <= con_wdata[CFG_OVL_BIT];
        cfg_vec   <= con_wdata[CFG_VEC_BIT];
        cfg_rmask <= con_wdata[CFG_RMASK_BIT];
        cfg_bpen  <= con_wdata[CFG_BPEN_LSB +: NUM_BP];
      end
    end
  end

  logic cmd_wr, cmd_resume, cmd_break, cmd_clear;
  assign cmd_wr     = con_wr && (con_sel == SEL_CMD);
  assign cmd_resume = cmd_wr && con_wdata[CMD_RESUME];
  assign cmd_break  = cmd_wr && con_wdata[CMD_BREAK];
  assign cmd_clear  = cmd_wr && con_wdata[CMD_CLEAR];

  // mode control
  mode_e mode_q;
  logic  nmi_q, soft_rst, hit_now, on_con;
  assign soft_rst = !tgt_rst_n && !cfg_rmask;
  assign on_con   = (mode_q == MODE_CONSOLE);

  ice_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .brk_evt  (hit_now || cmd_break),
    .resume   (cmd_resume),
    .mode_q   (mode_q),
    .nmi_q    (nmi_q)
  );

  // processor cycle steering
  logic acc, run_acc, ovl_hit, vec_hit, rd_acc;
  assign cpu_ready = !nmi_q;
  assign acc       = cpu_valid && cpu_ready;
  assign run_acc   = acc && !on_con;
  assign rd_acc    = acc && !cpu_we;
  assign ovl_hit   = cfg_ovl && (cpu_addr < OVL_TOP);
  assign vec_hit   = cfg_vec && (&cpu_addr[AW-1:VEC_AW]);

  assign tgt_valid   = run_acc && !(cpu_we && vec_hit);
  assign tgt_we      = tgt_valid && cpu_we;
  assign tgt_addr    = cpu_addr;
  assign tgt_addr_oe = !on_con;
  assign tgt_wdata   = cpu_wdata;
  assign tgt_data_oe = tgt_we;

  assign con_bus_valid = acc && on_con;
  assign con_bus_we    = con_bus_valid && cpu_we;
  assign con_bus_addr  = cpu_addr;
  assign con_bus_wdata = cpu_wdata;

  assign cpu_nmi        = nmi_q;
  assign cpu_on_console = on_con;

  // breakpoint comparators
  ice_bkpt_match #(.NUM_BP(NUM_BP), .AW(AW)) u_bkpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_rst),
    .flag_clr   (cmd_clear),
    .probe      (run_acc),
    .probe_addr (cpu_addr),
    .bp_addr    (bp_addr_q),
    .bp_en      (cfg_bpen),
    .hit_now    (hit_now),
    .hit_flags  (bkpt_hit)
  );

  // overlay and vector RAMs, loaded only in console mode
  logic          ld_acc, ovl_we, vec_we;
  logic [DW-1:0] ovl_rd, vec_rd;
  assign ld_ready = on_con;
  assign ld_acc   = ld_valid && ld_ready;
  assign ovl_we   = ld_acc && (ld_addr < OVL_TOP);
  assign vec_we   = ld_acc && (&ld_addr[AW-1:VEC_AW]);

  ice_sync_ram #(.IDX_W(OVL_AW), .DW(DW)) u_ovl_ram (
    .clk   (clk),
    .we    (ovl_we),
    .waddr (ld_addr[OVL_AW-1:0]),
    .wdata (ld_data),
    .re    (rd_acc && !on_con && ovl_hit),
    .raddr (cpu_addr[OVL_AW-1:0]),
    .rdata (ovl_rd)
  );

  ice_sync_ram #(.IDX_W(VEC_AW), .DW(DW)) u_vec_ram (
    .clk   (clk),
    .we    (vec_we),
    .waddr (ld_addr[VEC_AW-1:0]),
    .wdata (ld_data),
    .re    (rd_acc && !on_con && vec_hit),
    .raddr (cpu_addr[VEC_AW-1:0]),
    .rdata (vec_rd)
  );

  // read return path
  rsrc_e src_q;
  logic  rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_TGT;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        if (on_con)       src_q <= SRC_CON;
        else if (vec_hit) src_q <= SRC_VEC;
        else if (ovl_hit) src_q <= SRC_OVL;
        else              src_q <= SRC_TGT;
      end
    end
  end

  assign cpu_rvalid = rvalid_q;

  always_comb begin
    unique case (src_q)
      SRC_OVL: cpu_rdata = ovl_rd;
      SRC_VEC: cpu_rdata = vec_rd;
      SRC_CON: cpu_rdata = con_bus_rdata;
      default: cpu_rdata = tgt_rdata;
    endcase
  end
endmodule

// File: rtl/ice_bus_steer_chk.sv
`timescale 1ns/1ps
module ice_bus_steer_chk #(
  parameter int AW     = 16,
  parameter int NUM_BP = 4,
  parameter int VEC_AW = 4,
  localparam int SEL_W = $clog2(NUM_BP + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tgt_rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic              cpu_rvalid,
  input logic              cpu_nmi,
  input logic              tgt_valid,
  input logic              tgt_we,
  input logic [AW-1:0]     tgt_addr,
  input logic              tgt_addr_oe,
  input logic              tgt_data_oe,
  input logic              cpu_on_console,
  input logic [NUM_BP-1:0] bkpt_hit,
  input logic              con_wr,
  input logic [SEL_W-1:0]  con_sel,
  input logic [AW-1:0]     con_wdata,
  input logic              cfg_vec,
  input logic              cfg_rmask
);
  localparam logic [SEL_W-1:0] SEL_CMD = SEL_W'(NUM_BP + 1);

  assert_tgt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_on_console |-> (!tgt_valid && !tgt_we && !tgt_addr_oe && !tgt_data_oe));

  assert_nmi_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_nmi |=> !cpu_nmi);

  assert_nmi_on_console_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_nmi |-> (cpu_on_console && !cpu_ready));

  assert_data_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_data_oe |-> (tgt_we && tgt_valid && tgt_addr_oe));

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_valid && cpu_ready && !cpu_we));

  assert_vec_write_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_we && cfg_vec) |-> !(&tgt_addr[AW-1:VEC_AW]));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(bkpt_hit) & ~bkpt_hit)) |->
      ($past(con_wr && con_sel == SEL_CMD && con_wdata[2]) || $past(!tgt_rst_n && !cfg_rmask)));
endmodule

bind ice_bus_steer ice_bus_steer_chk #(.AW(AW), .NUM_BP(NUM_BP), .VEC_AW(VEC_AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tgt_rst_n      (tgt_rst_n),
  .cpu_valid      (cpu_valid),
  .cpu_ready      (cpu_ready),
  .cpu_we         (cpu_we),
  .cpu_rvalid     (cpu_rvalid),
  .cpu_nmi        (cpu_nmi),
  .tgt_valid      (tgt_valid),
  .tgt_we         (tgt_we),
  .tgt_addr       (tgt_addr),
  .tgt_addr_oe    (tgt_addr_oe),
  .tgt_data_oe    (tgt_data_oe),
  .cpu_on_console (cpu_on_console),
  .bkpt_hit       (bkpt_hit),
  .con_wr         (con_wr),
  .con_sel        (con_sel),
  .con_wdata      (con_wdata),
  .cfg_vec        (cfg_vec),
  .cfg_rmask      (cfg_rmask)
);

// File: tb/test_ice_bus_steer.sv
`timescale 1ns/1ps
module test_ice_bus_steer;
  localparam int AW = 16, DW = 8, NB = 4, SW = 3;

  logic clk = 1'b0, rst_n = 1'b0, tgt_rst_n = 1'b1;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic con_wr = 1'b0;
  logic [SW-1:0] con_sel = '0;
  logic [AW-1:0] con_wdata = '0;
  logic ld_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  logic cpu_ready, cpu_rvalid, cpu_nmi, tgt_valid, tgt_we, tgt_addr_oe, tgt_data_oe;
  logic con_bus_valid, con_bus_we, ld_ready, cpu_on_console;
  logic [DW-1:0] cpu_rdata, tgt_wdata, con_bus_wdata, tgt_rdata, con_bus_rdata;
  logic [AW-1:0] tgt_addr, con_bus_addr;
  logic [NB-1:0] bkpt_hit;

  // simple target and console memories: data derived from address
  logic [AW-1:0] tgt_last = '0, con_last = '0;
  always @(posedge clk) begin
    if (tgt_valid) tgt_last <= tgt_addr;
    if (con_bus_valid) con_last <= con_bus_addr;
  end
  assign tgt_rdata     = tgt_last[7:0] ^ 8'h5A;
  assign con_bus_rdata = con_last[7:0] ^ 8'hC3;

  ice_bus_steer i_ice_bus_steer (
    .clk(clk), .rst_n(rst_n), .tgt_rst_n(tgt_rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_nmi(cpu_nmi),
    .tgt_valid(tgt_valid), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_addr_oe(tgt_addr_oe),
    .tgt_wdata(tgt_wdata), .tgt_data_oe(tgt_data_oe), .tgt_rdata(tgt_rdata),
    .con_bus_valid(con_bus_valid), .con_bus_we(con_bus_we), .con_bus_addr(con_bus_addr),
    .con_bus_wdata(con_bus_wdata), .con_bus_rdata(con_bus_rdata),
    .con_wr(con_wr), .con_sel(con_sel), .con_wdata(con_wdata),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .cpu_on_console(cpu_on_console), .bkpt_hit(bkpt_hit)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read return: actual %0h expected none", cpu_rdata);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (cpu_rdata !== e) begin
          errors++;
          $display("FAIL %s read data: actual %0h expected %0h", t, cpu_rdata, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic start_cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
  endtask

  task automatic end_cyc();
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  // driver: pushes the expected read result into the scoreboard
  task automatic cpu_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    start_cyc(1'b0, a, '0);
    end_cyc();
  endtask

  task automatic con_write(input logic [SW-1:0] s, input logic [AW-1:0] d);
    con_wr = 1'b1; con_sel = s; con_wdata = d;
    @(negedge clk);
    con_wr = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic tgt_reset_pulse();
    tgt_rst_n = 1'b0;
    @(negedge clk);
    tgt_rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset nmi", cpu_nmi, 0);
    chk("R1 reset console", cpu_on_console, 0);
    chk("R1 reset flags", bkpt_hit, 0);
    chk("R1 reset ready", cpu_ready, 1);
    chk("R9 ld_ready in run", ld_ready, 0);

    // R1 / R2 pass-through write
    start_cyc(1'b1, 16'h1234, 8'hA5);
    chk("R1 tgt_valid", tgt_valid, 1);
    chk("R1 tgt_addr", tgt_addr, 16'h1234);
    chk("R1 tgt_wdata", tgt_wdata, 8'hA5);
    chk("R1 con quiet", con_bus_valid, 0);
    chk("R2 data oe on write", tgt_data_oe, 1);
    end_cyc();
    start_cyc(1'b0, 16'h2345, '0);
    chk("R2 data oe off on read", tgt_data_oe, 0);
    exp_q.push_back(8'h45 ^ 8'h5A); tag_q.push_back("R2 target read");
    end_cyc();

    // R8 break command
    con_write(3'd5, 16'h0002);
    chk("R8 nmi after break cmd", cpu_nmi, 1);
    chk("R6 console with nmi", cpu_on_console, 1);
    chk("R6 ready low in nmi", cpu_ready, 0);
    @(negedge clk);
    chk("R6 nmi single cycle", cpu_nmi, 0);
    chk("R9 ld_ready in console", ld_ready, 1);

    // R7 console cycles
    start_cyc(1'b1, 16'h0456, 8'h77);
    chk("R7 con valid", con_bus_valid, 1);
    chk("R7 con we", con_bus_we, 1);
    chk("R7 con addr", con_bus_addr, 16'h0456);
    chk("R7 tgt quiet", {tgt_valid, tgt_we, tgt_addr_oe, tgt_data_oe}, 0);
    end_cyc();
    cpu_rd(16'h0456, 8'h56 ^ 8'hC3, "R7 console read");

    // R9 loads
    load(16'h0010, 8'h3C);
    load(16'h00FF, 8'h7E);
    load(16'hFFFE, 8'h12);
    load(16'hFFF0, 8'h34);
    load(16'hD0FE, 8'hEE);

    // enable overlay + vectors, resume (R8)
    con_write(3'd4, 16'h0003);
    con_write(3'd5, 16'h0001);
    chk("R8 resume to run", cpu_on_console, 0);

    // R3 overlay reads
    cpu_rd(16'h0010, 8'h3C, "R3 overlay low");
    cpu_rd(16'hBFFF, 8'h7E, "R3 overlay top edge");
    cpu_rd(16'hC010, 8'h10 ^ 8'h5A, "R3 above overlay");
    // R4 vectors
    cpu_rd(16'hFFFE, 8'h12, "R4 vector read");
    cpu_rd(16'hFFF0, 8'h34, "R4 vector base");
    cpu_rd(16'hFFEF, 8'hEF ^ 8'h5A, "R4 below vectors");
    cpu_rd(16'hD0FE, 8'hFE ^ 8'h5A, "R9 dropped load");
    start_cyc(1'b1, 16'hFFFE, 8'h99);
    chk("R4 vector write blocked", tgt_valid, 0);
    end_cyc();
    cpu_rd(16'hFFFE, 8'h12, "R4 vector unchanged");

    // R3 overlay disabled
    con_write(3'd4, 16'h0002);
    cpu_rd(16'h0010, 8'h10 ^ 8'h5A, "R3 overlay off");

    // R5 breakpoints: entry 0 enabled, entry 2 disabled
    con_write(3'd0, 16'h3000);
    con_write(3'd2, 16'h4000);
    con_write(3'd4, 16'h0012);
    cpu_rd(16'h4000, 8'h00 ^ 8'h5A, "R5 disabled entry read");
    chk("R5 disabled entry no flag", bkpt_hit, 0);
    chk("R5 disabled entry no nmi", cpu_nmi, 0);
    cpu_rd(16'h3000, 8'h00 ^ 8'h5A, "R5 matched read");
    chk("R5 flag set", bkpt_hit, 4'b0001);
    chk("R6 nmi on hit", cpu_nmi, 1);
    chk("R6 console on hit", cpu_on_console, 1);
    @(negedge clk);
    chk("R6 nmi drops", cpu_nmi, 0);
    chk("R5 flag sticky", bkpt_hit, 4'b0001);
    con_write(3'd5, 16'h0004);
    chk("R5 flag cleared", bkpt_hit, 0);

    // R10 reset masking (still in console)
    con_write(3'd4, 16'h0016);
    tgt_reset_pulse();
    chk("R10 masked reset keeps console", cpu_on_console, 1);
    con_write(3'd4, 16'h0012);
    tgt_reset_pulse();
    chk("R10 unmasked reset to run", cpu_on_console, 0);
    cpu_rd(16'hFFFE, 8'h12, "R10 config survives");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule